// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Register CPU

This block is a small 8-bit processor with its own 16-byte memory. It executes one-byte instructions in a fixed sequence of phases, one instruction at a time. First it reads the instruction at the program counter, then it classifies the opcode, then it carries the instruction out. The machine holds four general registers, an instruction register, a 4-bit program counter and three result flags set by addition.

While reset is held, a program and its data are written into the memory through a byte-wide load port. When reset is released, the processor runs from address 0. The memory address, write data, read data and the read and write strobes are all visible at the ports, so every store the program makes can be observed on the bus.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, `mem_rd` and `mem_wr` are 0. One clock edge in reset clears all four registers, the program counter and the three flags to 0.
- R2: Each instruction begins with a cycle that has `mem_rd`=1 and `mem_addr` equal to the program counter. The first such cycle after reset has address 0. A non-load instruction takes 4 cycles and a load instruction takes 5.
- R3: Opcode 0010 (`ir[7:4]`) loads register A from memory at address `ir[3:0]`. Opcode 0001 loads register B in the same way. The data is captured one cycle after the read strobe.
- R4: Opcode 0100 writes register A to address `ir[3:0]`. It raises `mem_wr` for exactly one cycle, in the instruction's 4th cycle, with `mem_addr`=`ir[3:0]` and `mem_wdata` equal to A.
- R5: Opcode 1000 computes dst = dst + src (modulo 256). The source register is selected by `ir[3:2]` and the destination by `ir[1:0]`, with codes 00=A, 01=B, 10=C, 11=D.
- R6: After an add, `flag_z` is 1 when the 8-bit result is 0 and `flag_n` equals bit 7 of the result. `flag_v` is 1 when both operands have the same sign bit and the result's sign bit differs from it.
- R7: Loads, stores and undefined opcodes leave the three flags unchanged.
- R8: Opcodes other than 0001, 0010, 0100 and 1000 change no register or memory location. They only advance the program counter.
- R9: The program counter advances by one at the end of every instruction and wraps from 15 to 0.
- R10: With `load_en`=1, memory location `load_addr` takes `load_data` at the clock edge. The load port takes priority over a processor store.
- R11: A test program run from address 0 ends with 17 (00010001) stored to address 13. The program loads 3 from address 14 into A, loads 14 from address 15 into B, and adds B into A.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Program load write enable |
| load_addr | input | 4 | Program load address |
| load_data | input | 8 | Program load byte |
| mem_addr | output | 4 | Memory address bus |
| mem_wdata | output | 8 | Memory write data (register A) |
| mem_rdata | output | 8 | Registered memory read data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bench runs the test program and lets execution continue through a run of zero-opcode no-ops. It then wraps the program counter, which proves that wrap and no-op handling re-run the program identically. A signed-boundary program (0x7F+1, then 0x80+1) separates overflow from a plain negative result. A program that routes a value through C and D and then cancels 0x80+0x80 to zero checks every register selector and the zero flag with overflow. Its following load and store show that flags persist. A program made of assorted undefined opcodes checks that they only cost four cycles each. The exact cycle of every store tells a wrong phase count from a wrong result.

// File: rtl/acc_cpu.sv
module acc_cpu (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_en,
  input  logic [3:0] load_addr,
  input  logic [7:0] load_data,
  output logic [3:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic [7:0] mem_rdata,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       flag_z,
  output logic       flag_n,
  output logic       flag_v
);
  localparam int W = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_FETCH, S_FWAIT, S_DECODE, S_EXEC, S_LWAIT} state_t;
  typedef enum logic [2:0] {K_LDA, K_LDB, K_STA, K_ADD, K_NOP} kind_t;

  state_t        st;
  kind_t         kind;
  logic [AW-1:0] pc;
  logic [W-1:0]  ir;
  logic [W-1:0]  rf [4];
  logic [W-1:0]  mem [DEPTH];

  wire [1:0]   src = ir[3:2];
  wire [1:0]   dst = ir[1:0];
  wire [W-1:0] opa = rf[dst];
  wire [W-1:0] opb = rf[src];
  wire [W-1:0] sum = opa + opb;
  wire         is_load = (kind == K_LDA) || (kind == K_LDB);

  assign mem_addr  = (st == S_FETCH) ? pc : ir[3:0];
  assign mem_wdata = rf[0];
  assign mem_rd    = !rst && ((st == S_FETCH) || (st == S_EXEC && is_load));
  assign mem_wr    = !rst && (st == S_EXEC) && (kind == K_STA);

  always_ff @(posedge clk) begin
    if (load_en) mem[load_addr] <= load_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) mem_rdata <= '0;
    else if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FETCH;
      kind <= K_NOP;
      pc <= '0;
      ir <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_v <= 1'b0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else begin
      unique case (st)
        S_FETCH: st <= S_FWAIT;
        S_FWAIT: begin
          ir <= mem_rdata;
          st <= S_DECODE;
        end
        S_DECODE: begin
          unique case (ir[7:4])
            4'b0010: kind <= K_LDA;
            4'b0001: kind <= K_LDB;
            4'b0100: kind <= K_STA;
            4'b1000: kind <= K_ADD;
            default: kind <= K_NOP;
          endcase
          st <= S_EXEC;
        end
        S_EXEC: begin
          if (is_load) begin
            st <= S_LWAIT;
          end else begin
            if (kind == K_ADD) begin
              rf[dst] <= sum;
              flag_z <= (sum == '0);
              flag_n <= sum[W-1];
              flag_v <= (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
            end
            pc <= pc + 1'b1;
            st <= S_FETCH;
          end
        end
        S_LWAIT: begin
          if (kind == K_LDA) rf[0] <= mem_rdata;
          else rf[1] <= mem_rdata;
          pc <= pc + 1'b1;
          st <= S_FETCH;
        end
        default: st <= S_FETCH;
      endcase
    end
  end

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |-> (mem_rd && mem_addr == pc));

  p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
    ((st == S_EXEC && !is_load) || st == S_LWAIT) |=> (pc == $past(pc) + 4'd1));

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(st == S_EXEC && kind == K_ADD) |=> $stable({flag_z, flag_n, flag_v}));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC && kind == K_ADD) |=> (flag_z == (rf[$past(dst)] == '0)));

  p_load_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_LWAIT && kind == K_LDA) |=> (rf[0] == $past(mem_rdata)));
endmodule

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [3:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [3:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic       mem_rd, mem_wr, flag_z, flag_n, flag_v;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
  );

  always #4 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [3:0] a;
    logic [7:0] d;
    logic [2:0] f;
    string      tag;
  } item_t;

  item_t      q[$];
  logic [7:0] prog [16];
  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;

  task automatic expect_store(input int c, input logic [3:0] a, input logic [7:0] d,
                              input logic [2:0] f, input string tag);
    item_t it;
    it.cyc = c; it.a = a; it.d = d; it.f = f; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
  endtask

  task automatic boot_and_run();
    @(posedge clk); #1;
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      load_en = 1'b1; load_addr = i[3:0]; load_data = prog[i];
      @(posedge clk); #1;
    end
    load_en = 1'b0;
    @(negedge clk);
    checks++;
    if (mem_rd || mem_wr || {flag_z, flag_n, flag_v} != 3'b000) begin
      fails++;
      $display("FAIL R1: rd=%b wr=%b flags=%b, expected 0 0 000",
               mem_rd, mem_wr, {flag_z, flag_n, flag_v});
    end
    @(posedge clk); #1;
    rst = 1'b0;
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst) cyc = 0;
      else begin
        if (cyc == 0) begin
          checks++;
          if (!(mem_rd && mem_addr == 4'd0)) begin
            fails++;
            $display("FAIL R2: first fetch rd=%b addr=%0d, expected 1 0", mem_rd, mem_addr);
          end
        end
        if (mem_wr) begin
          checks++;
          if (mem_rd) begin
            fails++;
            $display("FAIL R12: rd=%b during write, expected 0", mem_rd);
          end
        end
        if (mem_wr && q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          checks++;
          if (cyc != it.cyc || mem_addr != it.a || mem_wdata != it.d ||
              {flag_z, flag_n, flag_v} != it.f) begin
            fails++;
            $display("FAIL %s: cyc=%0d addr=%0d data=%h znv=%b, expected cyc=%0d addr=%0d data=%h znv=%b",
                     it.tag, cyc, mem_addr, mem_wdata, {flag_z, flag_n, flag_v},
                     it.cyc, it.a, it.d, it.f);
          end
        end
        cyc++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2: watchdog expired with %0d stores outstanding, expected 0", q.size());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // Test program, then no-ops through address 12, load B at 13, wrap to 0.
    clear_prog();
    prog[0] = 8'h2E; prog[1] = 8'h1F; prog[2] = 8'h84; prog[3] = 8'h4D;
    prog[14] = 8'h03; prog[15] = 8'h0E;
    expect_store(17, 4'd13, 8'h11, 3'b000, "R11 R3 R4 R10");
    expect_store(84, 4'd13, 8'h11, 3'b000, "R9 R8 wrap rerun");
    boot_and_run();

    // Signed boundary: 0x7F+1 overflows, 0x80+1 is negative only.
    clear_prog();
    prog[0] = 8'h2E; prog[1] = 8'h1F; prog[2] = 8'h84; prog[3] = 8'h4D;
    prog[4] = 8'h84; prog[5] = 8'h4C;
    prog[14] = 8'h7F; prog[15] = 8'h01;
    expect_store(17, 4'd13, 8'h80, 3'b011, "R6 overflow");
    expect_store(25, 4'd12, 8'h81, 3'b010, "R6 negative");
    boot_and_run();

    // Registers C and D, zero with overflow, flags persist over load and store.
    clear_prog();
    prog[0] = 8'h2E; prog[1] = 8'h82; prog[2] = 8'h8B; prog[3] = 8'h8C;
    prog[4] = 8'h4D; prog[5] = 8'h1F; prog[6] = 8'h4C;
    prog[7] = 8'h87; prog[8] = 8'h8C; prog[9] = 8'h4B;
    prog[14] = 8'h80; prog[15] = 8'h05;
    expect_store(20, 4'd13, 8'h00, 3'b101, "R5 R6 zero");
    expect_store(29, 4'd12, 8'h00, 3'b101, "R7 flags kept");
    expect_store(41, 4'd11, 8'h85, 3'b010, "R5 B into D");
    boot_and_run();

    // Undefined opcodes between a load and a store; flags cleared by reset.
    clear_prog();
    prog[0] = 8'h2F; prog[1] = 8'h3C; prog[2] = 8'h9A; prog[3] = 8'hF7;
    prog[4] = 8'h4E; prog[15] = 8'h42;
    expect_store(20, 4'd14, 8'h42, 3'b000, "R8 R1 undefined opcodes");
    boot_and_run();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule